// File: doc/BRIEF.md
# I2C Byte Engine with Wait Insertion

This block is the bit-level heart of an I2C controller. It produces SCL and moves one byte at a time, most significant bit first, on open-drain SCL and SDA lines. Each byte is eight data clocks followed by one acknowledge clock. A single shift register holds the outgoing byte when transmitting and collects the incoming byte when receiving. Software writes and reads this register through a plain byte port.

After each byte the engine parks with SCL held low, so software can act before the bus moves on. A control input picks where it parks: after the falling edge of the ninth clock, or after the eighth clock and before the acknowledge clock. What ends the wait depends on the direction. A receiver continues on a release pulse or on a write of all ones. A transmitter continues on any data write. In either direction, a start or stop request ends the wait and the engine then produces that bus condition.

The high phase of SCL is timed only once the line is seen high. A far-end device that also holds SCL low therefore keeps the bus stopped until it lets go too.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, both line drivers are released (scl_pull = 0, sda_pull = 0), and waiting, byte_done and ack_rcvd are 0.
- R2: A start_req pulse while idle pulls SDA low while SCL is high. The engine then enters the wait with SCL low and byte_done = 0.
- R3: In transmit mode (ctl_tx = 1), the byte is sent most significant bit first on clocks 1 to 8. SDA is released on clock 9, and ack_rcvd becomes 1 if SDA was sampled low on that clock and 0 if it was high.
- R4: In receive mode (ctl_tx = 0), SDA is sampled on clocks 1 to 8 into rd_data, most significant bit first. The complete byte is readable on rd_data during the wait that follows.
- R5: With ctl_wait9 = 1, the engine enters the wait after the falling edge of clock 9. During the wait, scl_pull = 1, waiting = 1 and byte_done = 1.
- R6: With ctl_wait9 = 0, the engine enters the wait after clock 8, before the acknowledge clock. A release then runs clock 9 and goes straight on to the next byte, which again stops after its clock 8.
- R7: In receive mode, the engine pulls SDA low on clock 9 if ctl_ack_en was 1 when that clock began, and leaves SDA high if it was 0.
- R8: In receive mode, the wait ends on a rel_pulse or on a write of 8'hFF. A write of any other value loads rd_data and the wait continues.
- R9: In transmit mode, the wait ends on any data write. rel_pulse has no effect.
- R10: A start_req or stop_req during the wait ends it. Stop leaves both lines released, and waiting goes to 0. Start produces a repeated start and a new wait. A detected start or stop resets the bit count, so the next byte runs a full eight data clocks.
- R11: A high phase of SCL is timed only once SCL reads high. If another device still holds SCL low after the engine releases it, SCL stays low and no clock pulse is produced until that device releases it too.
- R12: byte_done is 1 only during a wait that follows a byte, and it returns to 0 in the cycle the wait ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Level read back from the SCL line |
| sda_in | input | 1 | Level read back from the SDA line |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| ctl_tx | input | 1 | 1 transmit, 0 receive |
| ctl_wait9 | input | 1 | 1 wait after clock 9, 0 wait after clock 8 |
| ctl_ack_en | input | 1 | Drive acknowledge on clock 9 when receiving |
| rel_pulse | input | 1 | Single-cycle wait release (receive side) |
| start_req | input | 1 | Single-cycle request for a start condition |
| stop_req | input | 1 | Single-cycle request for a stop condition |
| wr_en | input | 1 | Write strobe for the shift register |
| wr_data | input | 8 | Data written to the shift register |
| rd_data | output | 8 | Shift register contents |
| byte_done | output | 1 | Byte complete, set at the wait point |
| ack_rcvd | output | 1 | Acknowledge seen on clock 9 when transmitting |
| waiting | output | 1 | Engine is in the wait with SCL held low |

## Verification
Some properties are checked on every cycle. While waiting, SCL is held low. byte_done appears only inside a wait and is clear once the wait ends. The direction-specific release rules hold: a transmitter stays parked without a write, and a receiver stays parked without a release pulse or an all-ones write. A start or stop request always ends the wait. Other behaviour can only be shown by the bench's scenarios against a modelled far-end device: bit order, the acknowledge level on the ninth clock, the data clock count per byte in each wait mode, the bit count reset after a repeated start, and the bus staying low while the far end stretches SCL.

// File: rtl/i2c_byte_engine_pkg.sv
package i2c_byte_engine_pkg;

  // Engine sequencing states
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STA_SDA,   // SDA low with SCL high: start edge
    ST_RS_SDA,    // repeated start: release SDA under low SCL
    ST_RS_SCL,    // repeated start: release SCL, wait for high
    ST_WAIT,      // SCL held low until a release event
    ST_BIT_LO,    // low phase of a bit clock
    ST_BIT_HI,    // high phase of a bit clock
    ST_STP_LO,    // stop: both lines low
    ST_STP_SCL,   // stop: release SCL
    ST_STP_SDA    // stop: release SDA with SCL high
  } eng_state_e;

endpackage

// File: rtl/i2c_byte_engine_sync.sv
module i2c_byte_engine_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {WIDTH{RST_LVL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/i2c_byte_engine_timer.sv
module i2c_byte_engine_timer #(
  parameter int unsigned PERIOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);

  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (done) cnt_d = '0;
    else if (en)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/i2c_byte_engine_cond.sv
module i2c_byte_engine_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  // SDA edge while SCL stays high
  assign start_det = scl_p && scl_s && sda_p && !sda_s;
  assign stop_det  = scl_p && scl_s && !sda_p && sda_s;

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_byte_engine_pkg::*;
#(
  parameter int unsigned HALF_PERIOD = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              ctl_tx,
  input  logic              ctl_wait9,
  input  logic              ctl_ack_en,
  input  logic              rel_pulse,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              byte_done,
  output logic              ack_rcvd,
  output logic              waiting
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] ACK_IDX  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  eng_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              ack_lat_q, ack_lat_d;
  logic              ack_rx_q, ack_rx_d;
  logic              done_q, done_d;
  logic              scl_low_q, scl_low_d;
  logic              sda_low_q, sda_low_d;
  logic              tmr_en, tmr_clr, tmr_done;
  logic              scl_s, sda_s;
  logic              start_det, stop_det;
  logic              rel_evt;
  logic              bit_low;

  i2c_byte_engine_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_LVL(1'b1)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_in, sda_in}),
    .q    ({scl_s, sda_s})
  );

  i2c_byte_engine_cond cond_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_byte_engine_timer #(
    .PERIOD(HALF_PERIOD)
  ) timer_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tmr_clr),
    .en   (tmr_en),
    .done (tmr_done)
  );

  // Release event for the current direction
  assign rel_evt = ctl_tx ? wr_en
                          : (rel_pulse || (wr_en && (wr_data == {DATA_W{1'b1}})));

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    ack_lat_d = ack_lat_q;
    ack_rx_d  = ack_rx_q;
    done_d    = done_q;
    tmr_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_en) sh_d = wr_data;
        if (start_req) state_d = ST_STA_SDA;
      end
      ST_STA_SDA: begin
        tmr_en = 1'b1;
        if (tmr_done) state_d = ST_WAIT;
      end
      ST_RS_SDA: begin
        tmr_en = 1'b1;
        if (tmr_done) state_d = ST_RS_SCL;
      end
      ST_RS_SCL: begin
        tmr_en = scl_s;
        if (tmr_done) state_d = ST_STA_SDA;
      end
      ST_WAIT: begin
        if (wr_en) sh_d = wr_data;
        if (stop_req) begin
          state_d = ST_STP_LO;
          done_d  = 1'b0;
        end else if (start_req) begin
          state_d = ST_RS_SDA;
          done_d  = 1'b0;
        end else if (rel_evt) begin
          state_d = ST_BIT_LO;
          done_d  = 1'b0;
          if (cnt_q == ACK_IDX) ack_lat_d = ctl_ack_en;
          else                  cnt_d     = '0;
        end
      end
      ST_BIT_LO: begin
        tmr_en = 1'b1;
        if (tmr_done) state_d = ST_BIT_HI;
      end
      ST_BIT_HI: begin
        tmr_en = scl_s;
        if (tmr_done) begin
          if (cnt_q < ACK_IDX) sh_d = {sh_q[DATA_W-2:0], sda_s};
          else if (ctl_tx)     ack_rx_d = !sda_s;
          cnt_d = cnt_q + 1'b1;
          if ((cnt_q == LAST_BIT) && !ctl_wait9) begin
            state_d = ST_WAIT;
            done_d  = 1'b1;
          end else if (cnt_q == ACK_IDX) begin
            if (ctl_wait9) begin
              state_d = ST_WAIT;
              done_d  = 1'b1;
            end else begin
              state_d = ST_BIT_LO;
              cnt_d   = '0;
            end
          end else begin
            state_d = ST_BIT_LO;
            if (cnt_q == LAST_BIT) ack_lat_d = ctl_ack_en;
          end
        end
      end
      ST_STP_LO: begin
        tmr_en = 1'b1;
        if (tmr_done) state_d = ST_STP_SCL;
      end
      ST_STP_SCL: begin
        tmr_en = scl_s;
        if (tmr_done) state_d = ST_STP_SDA;
      end
      ST_STP_SDA: begin
        tmr_en = 1'b1;
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (start_det || stop_det) cnt_d = '0;
  end

  assign tmr_clr = (state_d != state_q);

  // SDA level for the bit clock being entered
  assign bit_low = (cnt_d < ACK_IDX) ? (ctl_tx && !sh_d[DATA_W-1])
                                     : (!ctl_tx && ack_lat_d);

  // Line drivers, decoded from the next state
  always_comb begin
    scl_low_d = 1'b0;
    sda_low_d = 1'b0;
    unique case (state_d)
      ST_IDLE:    begin scl_low_d = 1'b0; sda_low_d = 1'b0;    end
      ST_STA_SDA: begin scl_low_d = 1'b0; sda_low_d = 1'b1;    end
      ST_RS_SDA:  begin scl_low_d = 1'b1; sda_low_d = 1'b0;    end
      ST_RS_SCL:  begin scl_low_d = 1'b0; sda_low_d = 1'b0;    end
      ST_WAIT:    begin scl_low_d = 1'b1; sda_low_d = 1'b0;    end
      ST_BIT_LO:  begin scl_low_d = 1'b1; sda_low_d = bit_low; end
      ST_BIT_HI:  begin scl_low_d = 1'b0; sda_low_d = bit_low; end
      ST_STP_LO:  begin scl_low_d = 1'b1; sda_low_d = 1'b1;    end
      ST_STP_SCL: begin scl_low_d = 1'b0; sda_low_d = 1'b1;    end
      ST_STP_SDA: begin scl_low_d = 1'b0; sda_low_d = 1'b0;    end
      default:    begin scl_low_d = 1'b0; sda_low_d = 1'b0;    end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      ack_lat_q <= 1'b0;
      ack_rx_q  <= 1'b0;
      done_q    <= 1'b0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      ack_lat_q <= ack_lat_d;
      ack_rx_q  <= ack_rx_d;
      done_q    <= done_d;
      scl_low_q <= scl_low_d;
      sda_low_q <= sda_low_d;
    end
  end

  assign scl_pull  = scl_low_q;
  assign sda_pull  = sda_low_q;
  assign rd_data   = sh_q;
  assign byte_done = done_q;
  assign ack_rcvd  = ack_rx_q;
  assign waiting   = (state_q == ST_WAIT);

endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_tx,
  input logic              rel_pulse,
  input logic              start_req,
  input logic              stop_req,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              waiting,
  input logic              byte_done,
  input logic              scl_pull
);

  a_r5_wait_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> scl_pull);

  a_r12_done_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> waiting);

  a_r12_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(waiting) |-> !byte_done);

  a_r9_tx_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && ctl_tx && !wr_en && !start_req && !stop_req) |=> waiting);

  a_r8_rx_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !ctl_tx && !rel_pulse && !start_req && !stop_req &&
     !(wr_en && (wr_data == {DATA_W{1'b1}}))) |=> waiting);

  a_r10_request_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && (start_req || stop_req)) |=> !waiting);

endmodule

bind i2c_byte_engine i2c_byte_engine_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_tx   (ctl_tx),
  .rel_pulse(rel_pulse),
  .start_req(start_req),
  .stop_req (stop_req),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .waiting  (waiting),
  .byte_done(byte_done),
  .scl_pull (scl_pull)
);

// File: tb/i2c_byte_engine_tb_top.sv
module i2c_byte_engine_tb_top;

  logic clk;
  logic rst_n;
  logic scl_pull, sda_pull;
  logic ctl_tx, ctl_wait9, ctl_ack_en;
  logic rel_pulse, start_req, stop_req, wr_en;
  logic [7:0] wr_data, rd_data;
  logic byte_done, ack_rcvd, waiting;

  // Far-end device model
  logic sl_scl_low, sl_sda_low;
  logic scl_bus, sda_bus;
  int   sl_cnt, sl_rises, sl_starts, sl_stops;
  logic [7:0] sl_rx, sl_tx;
  logic sl_ack_seen, sl_is_tx, sl_give_ack, sl_stretch;

  int n_chk, n_bad;
  bit fin;

  assign scl_bus = !(scl_pull || sl_scl_low);
  assign sda_bus = !(sda_pull || sl_sda_low);

  i2c_byte_engine dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_bus),
    .sda_in    (sda_bus),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .ctl_tx    (ctl_tx),
    .ctl_wait9 (ctl_wait9),
    .ctl_ack_en(ctl_ack_en),
    .rel_pulse (rel_pulse),
    .start_req (start_req),
    .stop_req  (stop_req),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .byte_done (byte_done),
    .ack_rcvd  (ack_rcvd),
    .waiting   (waiting)
  );

  initial clk = 1'b0;
  always #5 clk = !clk;

  // Far end: sample on rising SCL
  always @(posedge scl_bus) begin
    if (sl_cnt < 8) sl_rx = {sl_rx[6:0], sda_bus};
    else if (sl_cnt == 8) sl_ack_seen = sda_bus;
    if (sl_cnt < 9) sl_cnt++;
    sl_rises++;
  end

  // Far end: change SDA on falling SCL, optionally stretch after clock 9
  always @(negedge scl_bus) begin
    if (sl_cnt == 9) begin
      sl_cnt = 0;
      if (sl_stretch) sl_scl_low = 1'b1;
    end
    if (sl_cnt < 8) sl_sda_low = sl_is_tx && !sl_tx[7 - sl_cnt];
    else            sl_sda_low = !sl_is_tx && sl_give_ack;
  end

  always @(negedge sda_bus) if (scl_bus === 1'b1) begin sl_starts++; sl_cnt = 0; end
  always @(posedge sda_bus) if (scl_bus === 1'b1) begin sl_stops++;  sl_cnt = 0; end

  // Expected-value functions
  function automatic int exp_ack_rcvd(input logic give);
    return give ? 1 : 0;
  endfunction

  function automatic int exp_ack_line(input logic ack_en);
    return ack_en ? 0 : 1;
  endfunction

  function automatic int exp_rises(input logic wait9, input logic from_ack_wait);
    int n;
    n = wait9 ? 9 : 8;
    if (from_ack_wait) n = n + 1;
    return n;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
  endtask

  task automatic do_rel();
    @(negedge clk) rel_pulse = 1'b1;
    @(negedge clk) rel_pulse = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic wait_wait(input string tag);
    int t;
    t = 0;
    while (waiting !== 1'b1 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 20000) chk({tag, " wait reached"}, 0, 1);
  endtask

  task automatic slave_load(input logic [7:0] b);
    sl_tx    = b;
    sl_is_tx = 1'b1;
    if (sl_cnt == 0) sl_sda_low = !b[7];
  endtask

  task automatic slave_rx(input logic give);
    sl_is_tx    = 1'b0;
    sl_give_ack = give;
    sl_sda_low  = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, g;
    logic ae, gv;
    void'($urandom(32'd20240611));
    n_chk = 0; n_bad = 0; fin = 1'b0;
    ctl_tx = 1'b1; ctl_wait9 = 1'b1; ctl_ack_en = 1'b1;
    rel_pulse = 1'b0; start_req = 1'b0; stop_req = 1'b0;
    wr_en = 1'b0; wr_data = 8'h00;
    sl_scl_low = 1'b0; sl_sda_low = 1'b0; sl_cnt = 0; sl_rises = 0;
    sl_starts = 0; sl_stops = 0; sl_rx = 8'h00; sl_tx = 8'h00;
    sl_ack_seen = 1'b0; sl_is_tx = 1'b0; sl_give_ack = 1'b1; sl_stretch = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sl_cnt = 0; sl_rises = 0; sl_starts = 0; sl_stops = 0;

    // R1 reset state
    chk("R1 scl_pull", scl_pull, 0);
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 waiting/byte_done/ack_rcvd", {waiting, byte_done, ack_rcvd}, 0);

    // R2 start from idle
    slave_rx(1'b1);
    do_start();
    wait_wait("R2");
    chk("R2 start seen", sl_starts, 1);
    chk("R2 byte_done", byte_done, 0);
    chk("R2 scl low", scl_bus, 0);

    // R3/R5 directed transmit, far end acknowledges
    sl_rises = 0;
    do_write(8'hA5);
    chk("R12 done cleared on release", byte_done, 0);
    wait_wait("R3");
    chk("R3 data on bus", sl_rx, 8'hA5);
    chk("R3 ack_rcvd", ack_rcvd, exp_ack_rcvd(1'b1));
    chk("R5 byte_done", byte_done, 1);
    chk("R5 scl held low", scl_bus, 0);
    chk("R5 clocks per byte", sl_rises, exp_rises(1'b1, 1'b0));

    // R9 release pulse ignored while transmitting
    do_rel();
    repeat (20) @(negedge clk);
    chk("R9 rel ignored", waiting, 1);
    chk("R9 no clock", scl_bus, 0);

    // R3 random transmit bytes with random acknowledge
    for (int i = 0; i < 6; i++) begin
      d  = 8'($urandom);
      gv = 1'($urandom);
      slave_rx(gv);
      do_write(d);
      wait_wait("R3 rnd");
      chk("R3 rnd data", sl_rx, d);
      chk("R3 rnd ack_rcvd", ack_rcvd, exp_ack_rcvd(gv));
    end

    // R4/R7/R8 receive, release by all-ones write, ack enabled
    ctl_tx = 1'b0; ctl_ack_en = 1'b1;
    slave_load(8'h3C);
    do_write(8'hFF);
    wait_wait("R8");
    chk("R4 rx data", rd_data, 8'h3C);
    chk("R7 ack driven", sl_ack_seen, exp_ack_line(1'b1));

    // R8 other value loads register only
    do_write(8'h12);
    repeat (20) @(negedge clk);
    chk("R8 non-FF keeps wait", waiting, 1);
    chk("R8 non-FF loaded", rd_data, 8'h12);

    // R7 ack disabled, release by pulse
    ctl_ack_en = 1'b0;
    slave_load(8'hC9);
    do_rel();
    wait_wait("R7");
    chk("R4 rx data pulse", rd_data, 8'hC9);
    chk("R7 no ack", sl_ack_seen, exp_ack_line(1'b0));

    // R4/R7 random receive bytes
    for (int i = 0; i < 4; i++) begin
      d  = 8'($urandom);
      ae = 1'($urandom);
      ctl_ack_en = ae;
      slave_load(d);
      if (1'($urandom)) do_write(8'hFF);
      else              do_rel();
      wait_wait("R4 rnd");
      chk("R4 rnd data", rd_data, d);
      chk("R7 rnd ack level", sl_ack_seen, exp_ack_line(ae));
    end

    // R6 wait after clock 8
    ctl_wait9 = 1'b0; ctl_ack_en = 1'b1;
    d = 8'h6E;
    slave_load(d);
    sl_rises = 0;
    do_rel();
    wait_wait("R6");
    chk("R6 rx data", rd_data, d);
    chk("R6 clocks", sl_rises, exp_rises(1'b0, 1'b0));
    chk("R6 byte_done", byte_done, 1);
    g = 8'($urandom);
    slave_load(g);
    sl_rises = 0;
    do_rel();
    wait_wait("R6 next");
    chk("R6 ack clock then byte", sl_rises, exp_rises(1'b0, 1'b1));
    chk("R6 next data", rd_data, g);
    chk("R6 ack driven", sl_ack_seen, exp_ack_line(1'b1));

    // R10 repeated start from the eighth-clock wait
    slave_rx(1'b1);
    do_start();
    wait_wait("R10 rs");
    chk("R10 repeated start", sl_starts, 2);
    chk("R10 byte_done", byte_done, 0);
    ctl_wait9 = 1'b1; ctl_tx = 1'b1;
    sl_rises = 0;
    d = 8'h9B;
    do_write(d);
    wait_wait("R10 byte");
    chk("R10 full byte after start", sl_rises, exp_rises(1'b1, 1'b0));
    chk("R10 data after start", sl_rx, d);

    // R11 far end stretches after clock 9
    sl_stretch = 1'b1;
    do_write(8'h5A);
    wait_wait("R11 arm");
    chk("R11 far end holds", sl_scl_low, 1);
    sl_stretch = 1'b0;
    sl_rises = 0;
    g = 8'($urandom);
    do_write(g);
    repeat (40) @(negedge clk);
    chk("R11 engine released", waiting, 0);
    chk("R11 scl stays low", scl_bus, 0);
    chk("R11 no clock", sl_rises, 0);
    sl_scl_low = 1'b0;
    wait_wait("R11 resume");
    chk("R11 data after stretch", sl_rx, g);

    // R10 stop from the wait
    slave_rx(1'b0);
    do_stop();
    repeat (100) @(negedge clk);
    chk("R10 stop seen", sl_stops, 1);
    chk("R10 lines released", {scl_pull, sda_pull}, 0);
    chk("R10 not waiting", waiting, 0);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule